// File: doc/BRIEF.md
# In-Frame Response Controller

This block runs the in-frame response segment of a J1850-style multiplex frame for one node. The frame engine tells it when the data part of a frame has ended and when the whole frame has ended. It also says whether the frame now closing was sent by this node. An enable input decides whether the response segment is handled at all.

When a frame from another node ends its data part, the block asks the bit-level transmitter to send one byte: the node's physical address, with no CRC. A request that loses arbitration is dropped and is not tried again in that frame.

When the node's own frame ends its data part, the block watches for a received byte before the end-of-frame strobe. On the end-of-frame strobe it pulses either a success output or a transmission-error output. The 8-bit address is captured while reset is held and is kept until the next reset.

Top module: `ifr_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tx_req_o`, `tx_err_o` and `ifr_ok_o` are 0.
- R2: The address on `node_addr_i` is captured in every cycle that reset is high. The value present in the last reset cycle is the one kept. Later changes to `node_addr_i` have no effect on `tx_byte_o` until the next reset.
- R3: With `ifr_en_i`=1, an `eod_i` pulse with `own_frame_i`=0 raises `tx_req_o` in the next cycle, with `tx_byte_o` equal to the captured address. The request stays high until a cycle with `tx_ack_i`=1, after which it is low. It is never raised again before the next `eod_i`, so at most one byte is sent per frame.
- R4: If `arb_lost_i` is 1 while `tx_req_o` is high, the request is low in the next cycle. It is not raised again within that frame.
- R5: With `ifr_en_i`=1, an `eod_i` pulse with `own_frame_i`=1 opens a check window. If at least one `rx_valid_i` pulse arrives in that window, `ifr_ok_o` is a one-cycle pulse in the cycle after `eof_i`, whatever the byte value. The window covers the cycles after `eod_i` up to and including the `eof_i` cycle.
- R6: If no `rx_valid_i` arrives in the check window of the node's own frame, `tx_err_o` is a one-cycle pulse in the cycle after `eof_i`, and `ifr_ok_o` stays 0.
- R7: An `rx_valid_i` pulse outside the check window, before `eod_i` or in the `eod_i` cycle itself, does not count as a response.
- R8: If `ifr_en_i` is 0 in the `eod_i` cycle, no request is raised and neither `tx_err_o` nor `ifr_ok_o` pulses at the following `eof_i`.
- R9: An `eof_i` pulse while a request is still pending with no acknowledge withdraws the request in the next cycle.
- R10: `tx_err_o` and `ifr_ok_o` are never high together and never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; address is captured while high |
| ifr_en_i | input | 1 | Enables in-frame response handling, sampled on `eod_i` |
| node_addr_i | input | 8 | Physical node address, captured during reset |
| eod_i | input | 1 | End-of-data strobe from the frame engine; opens the response segment |
| eof_i | input | 1 | End-of-frame strobe from the frame engine; closes the response segment |
| own_frame_i | input | 1 | Qualifies `eod_i`: 1 if this node sent the frame |
| tx_req_o | output | 1 | Request to the transmitter to send `tx_byte_o` |
| tx_byte_o | output | 8 | Response byte (the node address) |
| tx_ack_i | input | 1 | Transmitter has sent the response byte |
| arb_lost_i | input | 1 | Transmitter lost arbitration on the response byte |
| rx_valid_i | input | 1 | A byte was received from the bus |
| tx_err_o | output | 1 | Pulse: own frame got no response |
| ifr_ok_o | output | 1 | Pulse: own frame got a response |

## Verification
The block is driven with frames from other nodes and with the node's own frames, under both settings of the enable. The acknowledge, arbitration loss, received byte and end-of-frame strobe land in random cycles of the window. A request ended by an acknowledge is thus told apart from one ended by arbitration loss or by the end of frame. Received bytes placed before the window, on its opening edge, inside it and on its closing cycle separate a counted response from an ignored one. Directed cases cover re-reset with a new address, a changed address with no reset, and a disabled enable.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned IFR_ADDR_W = 8;

  // decoded frame-phase events for one cycle
  typedef struct packed {
    logic rsp_start;  // foreign frame, response segment opens
    logic chk_start;  // own frame, response segment opens
    logic close;      // frame ends
  } ifr_phase_t;
endpackage

// File: rtl/ifr_addr_latch.sv
module ifr_addr_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] addr_q;

  // follows the pins while reset is held; frozen once reset drops
  always_ff @(posedge clk) begin
    if (rst) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ifr_phase.sv
module ifr_phase
  import ifr_pkg::*;
(
  input  logic       en_i,
  input  logic       eod_i,
  input  logic       eof_i,
  input  logic       own_i,
  output ifr_phase_t ph_o
);
  always_comb begin
    ph_o.rsp_start = eod_i & en_i & ~own_i;
    ph_o.chk_start = eod_i & en_i & own_i;
    ph_o.close     = eof_i;
  end
endmodule

// File: rtl/ifr_responder.sv
module ifr_responder
  import ifr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  ifr_phase_t   ph_i,
  input  logic [W-1:0] addr_i,
  input  logic         ack_i,
  input  logic         lost_i,
  output logic         req_o,
  output logic [W-1:0] byte_o
);
  logic         req_q;
  logic [W-1:0] byte_q;

  // a single attempt per frame: once cleared, only a new opening re-arms
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      byte_q <= '0;
    end else if (ph_i.rsp_start) begin
      req_q  <= 1'b1;
      byte_q <= addr_i;
    end else if (req_q && (ack_i || lost_i || ph_i.close)) begin
      req_q  <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/ifr_monitor.sv
module ifr_monitor
  import ifr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ifr_phase_t ph_i,
  input  logic       rx_i,
  output logic       err_o,
  output logic       ok_o
);
  logic armed_q, seen_q, err_q, ok_q;
  logic got;

  // a byte arriving together with the closing strobe still counts
  assign got = seen_q | rx_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      ok_q  <= 1'b0;
      if (ph_i.chk_start) begin
        armed_q <= 1'b1;
        seen_q  <= 1'b0;
      end else if (armed_q) begin
        if (ph_i.close) begin
          armed_q <= 1'b0;
          seen_q  <= 1'b0;
          err_q   <= ~got;
          ok_q    <= got;
        end else if (rx_i) begin
          seen_q  <= 1'b1;
        end
      end
    end
  end

  assign err_o = err_q;
  assign ok_o  = ok_q;
endmodule

// File: rtl/ifr_ctrl.sv
module ifr_ctrl
  import ifr_pkg::*;
#(
  parameter int unsigned ADDR_W = IFR_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ifr_en_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              eod_i,
  input  logic              eof_i,
  input  logic              own_frame_i,
  output logic              tx_req_o,
  output logic [ADDR_W-1:0] tx_byte_o,
  input  logic              tx_ack_i,
  input  logic              arb_lost_i,
  input  logic              rx_valid_i,
  output logic              tx_err_o,
  output logic              ifr_ok_o
);
  logic [ADDR_W-1:0] addr;
  ifr_phase_t        ph;

  ifr_addr_latch #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .addr_i(node_addr_i), .addr_o(addr)
  );

  ifr_phase u_phase (
    .en_i(ifr_en_i), .eod_i(eod_i), .eof_i(eof_i), .own_i(own_frame_i), .ph_o(ph)
  );

  ifr_responder #(.W(ADDR_W)) u_rsp (
    .clk(clk), .rst(rst), .ph_i(ph), .addr_i(addr),
    .ack_i(tx_ack_i), .lost_i(arb_lost_i),
    .req_o(tx_req_o), .byte_o(tx_byte_o)
  );

  ifr_monitor u_mon (
    .clk(clk), .rst(rst), .ph_i(ph), .rx_i(rx_valid_i),
    .err_o(tx_err_o), .ok_o(ifr_ok_o)
  );
endmodule

// File: rtl/ifr_ctrl_chk.sv
module ifr_ctrl_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ifr_en_i,
  input logic              eod_i,
  input logic              eof_i,
  input logic              tx_req_o,
  input logic [ADDR_W-1:0] tx_byte_o,
  input logic              tx_ack_i,
  input logic              arb_lost_i,
  input logic              tx_err_o,
  input logic              ifr_ok_o
);
  AST_ERR_OK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tx_err_o && ifr_ok_o)); // R10

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    (tx_err_o || ifr_ok_o) |=> !(tx_err_o || ifr_ok_o)); // R10

  AST_ERR_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    tx_err_o |-> $past(eof_i)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o && !tx_ack_i && !arb_lost_i && !eof_i && !eod_i) |=> tx_req_o); // R3

  AST_NO_RETRY: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o && arb_lost_i && !eod_i) |=> !tx_req_o); // R4

  AST_EOF_DROP: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o && eof_i && !eod_i) |=> !tx_req_o); // R9

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (eod_i && !ifr_en_i && !tx_req_o) |=> !tx_req_o); // R8

  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o && $past(tx_req_o)) |-> $stable(tx_byte_o)); // R2
endmodule

bind ifr_ctrl ifr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ifr_en_i(ifr_en_i), .eod_i(eod_i), .eof_i(eof_i),
  .tx_req_o(tx_req_o), .tx_byte_o(tx_byte_o), .tx_ack_i(tx_ack_i),
  .arb_lost_i(arb_lost_i), .tx_err_o(tx_err_o), .ifr_ok_o(ifr_ok_o)
);

// File: tb/ifr_ctrl_test.sv
`timescale 1ns/1ps
module ifr_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic ifr_en_i, eod_i, eof_i, own_frame_i, tx_ack_i, arb_lost_i, rx_valid_i;
  logic [7:0] node_addr_i;
  logic tx_req_o, tx_err_o, ifr_ok_o;
  logic [7:0] tx_byte_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] exp_addr;

  always #5 clk = ~clk;

  ifr_ctrl uut (
    .clk(clk), .rst(rst), .ifr_en_i(ifr_en_i), .node_addr_i(node_addr_i),
    .eod_i(eod_i), .eof_i(eof_i), .own_frame_i(own_frame_i),
    .tx_req_o(tx_req_o), .tx_byte_o(tx_byte_o), .tx_ack_i(tx_ack_i),
    .arb_lost_i(arb_lost_i), .rx_valid_i(rx_valid_i),
    .tx_err_o(tx_err_o), .ifr_ok_o(ifr_ok_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic idle();
    eod_i = 0; eof_i = 0; own_frame_i = 0; tx_ack_i = 0; arb_lost_i = 0; rx_valid_i = 0;
  endtask

  task automatic do_reset(input logic [7:0] a);
    @(negedge clk);
    idle(); ifr_en_i = 1; rst = 1; node_addr_i = a;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", tx_req_o, 0);
    chk("R1 err in reset", tx_err_o, 0);
    chk("R1 ok in reset", ifr_ok_o, 0);
    rst = 0;
    exp_addr = a;
    @(negedge clk);
    chk("R1 req after reset", tx_req_o, 0);
    chk("R1 pulses after reset", int'(tx_err_o) + int'(ifr_ok_o), 0);
  endtask

  // expected pulse outcome of a frame: 0 none, 1 ok, 2 error
  function automatic int exp_result(input bit en, input bit own, input int rx_at, input int len);
    if (!en || !own) return 0;
    return (rx_at >= 1 && rx_at <= len) ? 1 : 2;
  endfunction

  // One frame. Positions count cycles after the eod cycle (1..len, eof at len).
  // rx_at=0 puts a byte on the eod cycle itself; rx_pre puts one before it.
  task automatic frame(input bit en, input bit own, input int ack_at, input int arb_at,
                       input int rx_at, input int len, input bit rx_pre);
    bit req_exp;
    int res;
    if (rx_pre) begin
      rx_valid_i = 1;
      @(negedge clk);
      rx_valid_i = 0;
    end
    ifr_en_i = en; own_frame_i = own; eod_i = 1; rx_valid_i = (rx_at == 0);
    @(negedge clk);
    eod_i = 0; rx_valid_i = 0; own_frame_i = 0;
    req_exp = en && !own;
    chk(en ? "R3 request raise" : "R8 no request when disabled", tx_req_o, req_exp);
    if (req_exp) chk("R2 byte is latched address", tx_byte_o, exp_addr);
    for (int k = 1; k <= len; k++) begin
      tx_ack_i = (k == ack_at); arb_lost_i = (k == arb_at);
      rx_valid_i = (k == rx_at); eof_i = (k == len);
      @(negedge clk);
      if (req_exp && (tx_ack_i || arb_lost_i || eof_i)) req_exp = 0;
      idle();
      chk(k == arb_at ? "R4 drop on arbitration loss" :
          (k == len ? "R9 request state at eof" : "R3 request level"), tx_req_o, req_exp);
      if (tx_req_o && req_exp) chk("R2 byte held", tx_byte_o, exp_addr);
      if (k < len) chk("R10 no early pulse", int'(tx_err_o) + int'(ifr_ok_o), 0);
    end
    res = exp_result(en, own, rx_at, len);
    chk(rx_at <= 0 ? "R7 ok pulse" : "R5 ok pulse", ifr_ok_o, res == 1);
    chk("R6 error pulse", tx_err_o, res == 2);
    @(negedge clk);
    chk("R10 pulse one cycle", int'(tx_err_o) + int'(ifr_ok_o), 0);
    chk("R4 no retry in frame", tx_req_o, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; idle(); ifr_en_i = 1; node_addr_i = 8'h00;
    do_reset(8'h5A);

    // directed corners
    frame(1, 0, 3, 0, 0, 6, 0);   // R3 ack ends request
    frame(1, 0, 0, 2, 0, 6, 0);   // R4 arbitration loss
    frame(1, 0, 0, 0, -1, 4, 0);  // R9 eof withdraws request
    frame(1, 1, 0, 0, 2, 5, 0);   // R5 response inside
    frame(1, 1, 0, 0, 5, 5, 0);   // R5 response on eof cycle
    frame(1, 1, 0, 0, -1, 5, 0);  // R6 no response
    frame(1, 1, 0, 0, -1, 5, 1);  // R7 byte before window
    frame(1, 1, 0, 0, 0, 5, 0);   // R7 byte on eod cycle
    frame(0, 0, 2, 0, 0, 5, 0);   // R8 disabled foreign frame
    frame(0, 1, 0, 0, 2, 5, 0);   // R8 disabled own frame

    // R2 address change without reset is ignored
    @(negedge clk); node_addr_i = 8'hC3;
    frame(1, 0, 4, 0, 0, 6, 0);
    do_reset(8'hC3);
    frame(1, 0, 2, 0, 0, 5, 0);

    // random frames
    for (int i = 0; i < 300; i++) begin
      int len;
      len = 2 + ($urandom % 8);
      frame($urandom % 4 != 0, $urandom % 2 == 1,
            int'($urandom % (len + 3)) - 1, int'($urandom % (len + 3)) - 1,
            int'($urandom % (len + 2)) - 1, len, $urandom % 4 == 0);
      if (i % 100 == 99) begin
        logic [7:0] a;
        a = 8'($urandom);
        do_reset(a);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule